// File: doc/BRIEF.md
# ADC Conversion-Start Trigger Timer

This block generates the pulses that start analog-to-digital conversions. It holds several independent trigger channels, two by default, and each channel drives the start input of its own converter. A channel runs in one of two modes.

In free-running mode the channel counts clocks on its own and emits a start pulse once every programmed period. In delayed mode the channel watches the reload synchronisation signal of a PWM generator. Each rising edge of that signal begins a programmable delay, and when the delay has elapsed the channel emits a single start pulse. Delayed mode places the converter's sampling instant at a chosen offset inside the PWM cycle.

Each channel has its own enable, mode select, count value and sync input, and so its own timing. A start output is high for one clock for each trigger. The mode is captured when the channel is enabled. The count value is captured when a count begins.

Top module: `adc_trig_timer`

## Requirements
- R1: While reset is asserted and after it is released, every `adc_start` bit is low and every channel is idle until it is enabled.
- R2: Free-running mode is `cfg_mode` bit = 0. The enable is first sampled high at clock edge E with period P taken from `cfg_value`. The channel then pulses in the cycles that follow edges E+P, E+2P and so on. A value of 0 behaves as 1, which gives a pulse after every edge.
- R3: Delayed mode is `cfg_mode` bit = 1. The first clock edge at which the channel's `pwm_sync` is sampled high after being sampled low is the sync edge T. With delay D taken from `cfg_value`, the channel pulses for exactly one cycle, the cycle that follows edge T+D.
- R4: In delayed mode a delay of 0 gives the pulse in the cycle right after the sync edge T.
- R5: A sync edge that arrives while a delay is counting restarts the count with the newly sampled value, and the earlier trigger never fires. This also holds when the new sync edge falls on the same edge at which the earlier delay would have expired.
- R6: Changing `cfg_value` has no effect on a count in progress. A delay keeps the value sampled at its sync edge, and a free-running period keeps the value sampled at enable.
- R7: The mode is sampled when the channel is enabled. Changing `cfg_mode` while the channel is enabled has no effect, and sync edges have no effect on a channel running free.
- R8: At the first edge at which the enable is sampled low, the channel stops pulsing and drops any pending delayed trigger. Sync edges seen while the channel is disabled, or at the same edge at which it is enabled, start no count.
- R9: Channels are independent. Channel i uses bit i of `pwm_sync`, `cfg_enable` and `cfg_mode`, bits [i*CNT_W +: CNT_W] of `cfg_value`, and drives bit i of `adc_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_sync | input | NUM_CH | PWM reload sync, one per channel |
| cfg_enable | input | NUM_CH | Channel enable |
| cfg_mode | input | NUM_CH | 0 = free-running, 1 = delayed after sync |
| cfg_value | input | NUM_CH*CNT_W | Period (free-running) or delay (delayed), per channel |
| adc_start | output | NUM_CH | One-clock conversion-start pulses |

## Verification
Two events can fall on the same clock edge: a fresh sync edge, and the expiry of the delay that an earlier sync edge started. The bench provokes this by issuing a second sync edge exactly D cycles after the first. The scoreboard expects only the pulse derived from the second edge, so a stray pulse or a shifted pulse is a mismatch. Disable is made to coincide with a pending delay in the same way, and the bench checks that the pulse is withheld.

// File: rtl/adc_trig_pkg.sv
`timescale 1ns/1ps
// Shared types for the ADC trigger timer.
// Assumes: nothing beyond a standard SystemVerilog package scope.
package adc_trig_pkg;

    // Channel operating mode, as carried on the cfg_mode bit.
    typedef enum logic {
        TRIG_PERIODIC = 1'b0,
        TRIG_DELAYED  = 1'b1
    } trig_mode_t;

    // Channel sequencing state.
    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,   // disabled, nothing counting
        CH_FREE  = 2'd1,   // free-running period counter
        CH_ARMED = 2'd2,   // delayed mode, waiting for a sync edge
        CH_COUNT = 2'd3    // delayed mode, delay in progress
    } chan_state_t;

endpackage

// File: rtl/adc_trig_edge.sv
`timescale 1ns/1ps
// Rising-edge detector for the PWM reload sync input of one channel.
// Does:    flags the first clock edge at which sync_in is sampled high
//          after it was sampled low.
// Assumes: sync_in is already synchronous to clk.
module adc_trig_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    output logic edge_hit
);

    logic prev_q;

    // Remember the sync level from the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= sync_in;
        end
    end

    // A rise is present when the level is high now and was low before.
    assign edge_hit = sync_in & ~prev_q;

endmodule

// File: rtl/adc_trig_channel.sv
`timescale 1ns/1ps
// One trigger channel: free-running period counter or sync-delayed one-shot.
// Does:    captures the mode at enable, captures the period at enable or
//          the delay at each sync edge, and emits a registered one-clock
//          start pulse.
// Assumes: sync_edge is a one-cycle flag from the edge detector; the
//          configuration inputs are synchronous to clk.
module adc_trig_channel
    import adc_trig_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             mode_sel,
    input  logic [CNT_W-1:0] value,
    input  logic             sync_edge,
    output logic             start_pulse
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    chan_state_t      st_q, st_n;
    logic [CNT_W-1:0] remain_q, remain_n;
    logic [CNT_W-1:0] period_q, period_n;
    logic             start_q, fire;
    logic [CNT_W-1:0] load_period;

    // A zero period is treated as a period of one clock.
    assign load_period = (value == '0) ? ONE : value;

    // Next-state and fire decision for the channel sequencer.
    always_comb begin
        st_n     = st_q;
        remain_n = remain_q;
        period_n = period_q;
        fire     = 1'b0;
        if (!enable) begin
            st_n = CH_IDLE;
        end else begin
            unique case (st_q)
                CH_IDLE: begin
                    if (trig_mode_t'(mode_sel) == TRIG_PERIODIC) begin
                        st_n     = CH_FREE;
                        remain_n = load_period;
                        period_n = load_period;
                    end else begin
                        st_n = CH_ARMED;
                    end
                end
                CH_FREE: begin
                    if (remain_q == ONE) begin
                        fire     = 1'b1;
                        remain_n = period_q;
                    end else begin
                        remain_n = remain_q - ONE;
                    end
                end
                CH_ARMED, CH_COUNT: begin
                    if (sync_edge) begin
                        if (value == '0) begin
                            fire = 1'b1;
                            st_n = CH_ARMED;
                        end else begin
                            remain_n = value;
                            st_n     = CH_COUNT;
                        end
                    end else if (st_q == CH_COUNT) begin
                        if (remain_q == ONE) begin
                            fire = 1'b1;
                            st_n = CH_ARMED;
                        end else begin
                            remain_n = remain_q - ONE;
                        end
                    end
                end
                default: st_n = CH_IDLE;
            endcase
        end
    end

    // Sequencer registers and the registered start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= CH_IDLE;
            remain_q <= '0;
            period_q <= ONE;
            start_q  <= 1'b0;
        end else begin
            st_q     <= st_n;
            remain_q <= remain_n;
            period_q <= period_n;
            start_q  <= fire;
        end
    end

    assign start_pulse = start_q;

    // R8
    disable_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (st_q == CH_IDLE && !start_pulse));

    // R4
    zero_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && sync_edge && value == '0 &&
         (st_q == CH_ARMED || st_q == CH_COUNT)) |=> start_pulse);

    // R5
    restart_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && sync_edge && value != '0 && st_q == CH_COUNT)
        |=> (!start_pulse && st_q == CH_COUNT && remain_q == $past(value)));

    // R2
    period_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_FREE) |-> (remain_q != '0 && remain_q <= period_q));

    // R7
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_FREE && enable) |=> (st_q == CH_FREE && $stable(period_q)));

endmodule

// File: rtl/adc_trig_timer.sv
`timescale 1ns/1ps
// ADC conversion-start trigger timer with NUM_CH independent channels.
// Does:    per channel, detects PWM sync rises and runs a free-running or
//          sync-delayed trigger counter that drives one adc_start bit.
// Assumes: all inputs are synchronous to clk; channel i owns bit i of the
//          per-channel vectors and the slice [i*CNT_W +: CNT_W] of cfg_value.
module adc_trig_timer #(
    parameter int NUM_CH = 2,
    parameter int CNT_W  = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CH-1:0]       pwm_sync,
    input  logic [NUM_CH-1:0]       cfg_enable,
    input  logic [NUM_CH-1:0]       cfg_mode,
    input  logic [NUM_CH*CNT_W-1:0] cfg_value,
    output logic [NUM_CH-1:0]       adc_start
);

    logic [NUM_CH-1:0] sync_rise;

    // One edge detector and one trigger channel per converter.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        adc_trig_edge u_edge (
            .clk      (clk),
            .rst_n    (rst_n),
            .sync_in  (pwm_sync[ch]),
            .edge_hit (sync_rise[ch])
        );

        adc_trig_channel #(.CNT_W(CNT_W)) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .enable      (cfg_enable[ch]),
            .mode_sel    (cfg_mode[ch]),
            .value       (cfg_value[ch*CNT_W +: CNT_W]),
            .sync_edge   (sync_rise[ch]),
            .start_pulse (adc_start[ch])
        );
    end

endmodule

// File: tb/tb_adc_trig_timer.sv
`timescale 1ns/1ps
module tb_adc_trig_timer;

    localparam int NUM_CH = 2;
    localparam int CNT_W  = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NUM_CH-1:0]       pwm_sync, cfg_enable, cfg_mode;
    logic [NUM_CH*CNT_W-1:0] cfg_value;
    logic [NUM_CH-1:0]       adc_start;

    logic             sync_a [NUM_CH];
    logic             en_a   [NUM_CH];
    logic             mode_a [NUM_CH];
    logic [CNT_W-1:0] val_a  [NUM_CH];

    int cyc = 0;
    int n_cmp = 0;
    int n_bad = 0;
    bit mon_on = 1'b0;
    bit done = 1'b0;

    int    expq [NUM_CH][$];
    string tagq [NUM_CH][$];

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always_comb begin
        for (int i = 0; i < NUM_CH; i++) begin
            pwm_sync[i]                 = sync_a[i];
            cfg_enable[i]               = en_a[i];
            cfg_mode[i]                 = mode_a[i];
            cfg_value[i*CNT_W +: CNT_W] = val_a[i];
        end
    end

    adc_trig_timer #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .pwm_sync(pwm_sync), .cfg_enable(cfg_enable),
        .cfg_mode(cfg_mode), .cfg_value(cfg_value), .adc_start(adc_start)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic push_exp(input int ch, input int c, input string tag);
        expq[ch].push_back(c);
        tagq[ch].push_back(tag);
    endtask

    // Monitor: pops expected pulse cycles and compares with observed pulses.
    always @(negedge clk) begin
        if (mon_on) begin
            for (int ch = 0; ch < NUM_CH; ch++) begin
                while (expq[ch].size() > 0 && expq[ch][0] < cyc) begin
                    n_cmp++; n_bad++;
                    $display("FAIL %s ch%0d: actual no pulse, expected pulse at cycle %0d",
                             tagq[ch][0], ch, expq[ch][0]);
                    void'(expq[ch].pop_front()); void'(tagq[ch].pop_front());
                end
                if (adc_start[ch]) begin
                    n_cmp++;
                    if (expq[ch].size() > 0 && expq[ch][0] == cyc) begin
                        void'(expq[ch].pop_front()); void'(tagq[ch].pop_front());
                    end else begin
                        n_bad++;
                        $display("FAIL R3/R7/R8 ch%0d: actual pulse at cycle %0d, expected %0d",
                                 ch, cyc, (expq[ch].size() > 0) ? expq[ch][0] : -1);
                    end
                end
            end
        end
    end

    // Free-running run of n pulses, optionally disturbing value, mode and sync.
    task automatic run_free(input int ch, input int p, input int n, input bit disturb);
        int e, eff;
        mode_a[ch] = 1'b0; val_a[ch] = CNT_W'(p); en_a[ch] = 1'b1;
        e = cyc + 1;
        eff = (p == 0) ? 1 : p;
        for (int i = 1; i <= n; i++) push_exp(ch, e + i*eff, (p == 0) ? "R2-zero" : "R2");
        if (disturb) begin
            repeat (2) @(negedge clk);
            val_a[ch] = CNT_W'(7);   // R6: period change ignored
            mode_a[ch] = 1'b1;       // R7: mode change ignored
            sync_a[ch] = 1'b1;       // R7: sync ignored while running free
            @(negedge clk);
            sync_a[ch] = 1'b0;
        end
        while (cyc < e + n*eff) @(negedge clk);
        en_a[ch] = 1'b0;
        @(negedge clk);
    endtask

    // Sync pulse with delay d; expected pulse pushed when exp_on is set.
    task automatic sync_pulse(input int ch, input int d, input bit exp_on, input string tag);
        val_a[ch] = CNT_W'(d);
        sync_a[ch] = 1'b1;
        if (exp_on) push_exp(ch, cyc + 1 + d, tag);
        @(negedge clk);
        sync_a[ch] = 1'b0;
    endtask

    task automatic arm_delayed(input int ch);
        mode_a[ch] = 1'b1; en_a[ch] = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic delayed_seq(input int ch);
        arm_delayed(ch);
        sync_pulse(ch, 3, 1'b1, "R3");
        repeat (6) @(negedge clk);
        sync_pulse(ch, 0, 1'b1, "R4");
        repeat (3) @(negedge clk);
        sync_pulse(ch, 6, 1'b1, "R6");
        @(negedge clk);
        val_a[ch] = CNT_W'(1);     // R6: changed mid-delay, must not matter
        repeat (10) @(negedge clk);
        // R5: restart in the middle of a delay
        sync_pulse(ch, 6, 1'b0, "");
        repeat (2) @(negedge clk);
        sync_pulse(ch, 4, 1'b1, "R5");
        repeat (8) @(negedge clk);
        // R5: new sync lands on the very edge the old delay expires
        sync_pulse(ch, 5, 1'b0, "");
        repeat (4) @(negedge clk);
        sync_pulse(ch, 2, 1'b1, "R5-coincide");
        repeat (6) @(negedge clk);
        en_a[ch] = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < NUM_CH; i++) begin
            sync_a[i] = 1'b0; en_a[i] = 1'b0; mode_a[i] = 1'b0; val_a[i] = '0;
        end
        // R1: outputs low during reset
        repeat (4) begin
            @(negedge clk);
            n_cmp++;
            if (adc_start !== '0) begin
                n_bad++;
                $display("FAIL R1: actual adc_start %b, expected 00", adc_start);
            end
        end
        rst_n = 1'b1;
        mon_on = 1'b1;
        repeat (3) @(negedge clk);

        // R9: both channels at once, ch0 free-running, ch1 delayed
        fork
            run_free(0, 4, 6, 1'b1);
            delayed_seq(1);
        join
        repeat (3) @(negedge clk);

        // R2: zero period means every clock
        run_free(1, 0, 4, 1'b0);
        run_free(0, 3, 3, 1'b0);

        // R8: disable drops a pending trigger
        arm_delayed(0);
        sync_pulse(0, 8, 1'b0, "");
        repeat (3) @(negedge clk);
        en_a[0] = 1'b0;
        repeat (12) @(negedge clk);
        // R8: sync while disabled starts nothing
        sync_pulse(0, 1, 1'b0, "");
        repeat (4) @(negedge clk);
        // R8: sync on the enabling edge is ignored
        mode_a[0] = 1'b1; en_a[0] = 1'b1; val_a[0] = CNT_W'(1); sync_a[0] = 1'b1;
        @(negedge clk);
        sync_a[0] = 1'b0;
        repeat (6) @(negedge clk);
        sync_pulse(0, 2, 1'b1, "R8-after");
        repeat (5) @(negedge clk);
        // R7: mode captured at enable, later change to free-running ignored
        mode_a[0] = 1'b0;
        repeat (8) @(negedge clk);
        sync_pulse(0, 1, 1'b1, "R7");
        repeat (5) @(negedge clk);
        en_a[0] = 1'b0;

        repeat (20) @(negedge clk);
        for (int ch = 0; ch < NUM_CH; ch++) begin
            n_cmp++;
            if (expq[ch].size() != 0) begin
                n_bad++;
                $display("FAIL R3 ch%0d: actual %0d pulses outstanding, expected 0",
                         ch, expq[ch].size());
            end
        end
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual run still busy, expected finished");
            summary();
            $finish;
        end
    end

endmodule